// File: doc/BRIEF.md
# Quad-data-rate burst SRAM model

A synthesizable behavioural model of a synchronous SRAM with a dedicated read data port and a dedicated write data port. Both ports work at the same time and share one address bus. Every command moves a burst of four words. Data moves at two words per command period. The model runs from a single beat clock at twice the command rate. Beats alternate between a command beat and an address-only beat. The first rising edge after reset is a command edge.

A read takes its address on the command edge. A write takes its select on the command edge and its address on the next edge. A write then takes four data beats, each with active-low byte-lane selects. The read pipeline returns data after either a long latency (5 beats) or a short latency (2 beats), and a valid flag marks the beats that carry data. A finished write waits in a pending line register for two beats before it is written into the array. Reads see the pending line merged over the array, so they always return the newest data.

Internally, each port runs its own state machine. The read port uses RD_IDLE, then RD_HOLD1, RD_HOLD2 and RD_HOLD3. A command accepted in RD_IDLE walks through the three hold states back to RD_IDLE. The write port uses WR_IDLE, then WR_ADDR, then WR_BEAT0 to WR_BEAT3. A command in WR_IDLE moves to WR_ADDR and then through the four beat states. In WR_BEAT3 the port moves to WR_BEAT0 if a command was seen in WR_BEAT2, and otherwise to WR_IDLE. The pending line moves from PD_EMPTY to PD_HOLD on a finished burst and from PD_HOLD to PD_COMMIT. In PD_COMMIT it writes the array and returns to PD_EMPTY, or goes back to PD_HOLD if a new burst finishes at the same time.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, `rvalid` is 0 and `rdata` is 0 until a read delivers data.
- R2: Edges alternate between command edges and address edges, starting with a command edge right after reset. The port selects and the read address are sampled only on command edges. The write address is sampled on the edge that follows an accepted write command. Selects asserted on address edges are ignored.
- R3: A write accepted on command edge c takes its data on edges c+2 to c+5. Beat k with start address a is stored at word offset (a[1:0]+k) mod 4 of line a[AW-1:2].
- R4: A read burst returns four words on consecutive beats. Word k comes from offset (a[1:0]+k) mod 4 of the addressed line.
- R5: With `lat_long`=1, the first read word is visible after the 5th edge following the command edge. With `lat_long`=0, it is visible after the 2nd edge.
- R6: `rvalid` is 1 exactly on the beats that carry read data, and `rdata` is 0 on every other beat.
- R7: A command on the command edge two beats after an accepted command of the same port is ignored. A command four beats after it is accepted, so bursts follow each other with no gap.
- R8: A read and a write accepted on the same command edge both complete with no effect on each other's timing.
- R9: A read returns the effect of every write whose last data beat was sampled before the read's command edge, whether or not it has been committed. A write still taking data does not affect it.
- R10: `wbyte_n` bit i low stores bits 9i+8:9i of that beat's word. A high bit leaves that lane's previous contents unchanged.
- R11: A finished write is committed to the array two beats after its last data beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_long | input | 1 | 1 selects 5-beat read latency, 0 selects 2-beat |
| rd_sel_n | input | 1 | Active-low read select, sampled on command edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on command edges |
| addr | input | AW | Shared word address: read address on command edges, write address on the following edge |
| wdata | input | WORD_W | Write data, one word per beat |
| wbyte_n | input | LANES | Active-low byte-lane selects for the current write beat |
| rdata | output | WORD_W | Read data, one word per beat, zero when idle |
| rvalid | output | 1 | High on beats carrying read data |

## Verification
The assertions assume three things about the inputs. `lat_long` changes only while no read data is in flight. `LINES` is a power of two. Reads never target a line that has never been written. The latency properties and the contiguous-valid property rely on the first of these. The stimulus keeps to all three. It fills every line before the first read, and it switches latency only after several idle command periods. It also drives selects on address beats and data on unused beats as noise, because the design must ignore those values and no assertion relies on them being quiet.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BURST     = 4;
    localparam int LAT_LONG  = 5;
    localparam int LAT_SHORT = 2;

    typedef enum logic [1:0] {
        RD_IDLE, RD_HOLD1, RD_HOLD2, RD_HOLD3
    } rd_state_e;

    typedef enum logic [2:0] {
        WR_IDLE, WR_ADDR, WR_BEAT0, WR_BEAT1, WR_BEAT2, WR_BEAT3
    } wr_state_e;

    typedef enum logic [1:0] {
        PD_EMPTY, PD_HOLD, PD_COMMIT
    } pend_state_e;
endpackage

// File: rtl/qdr_array.sv
module qdr_array import qdr_pkg::*; #(
    parameter int LINES  = 16,
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input  logic                                clk,
    input  logic                                commit,
    input  logic                                pend_valid,
    input  logic [$clog2(LINES)-1:0]            pend_line,
    input  logic [BURST-1:0][WORD_W-1:0]        pend_data,
    input  logic [BURST-1:0][LANES-1:0]         pend_be,
    input  logic [$clog2(LINES)-1:0]            rd_line,
    output logic [BURST-1:0][WORD_W-1:0]        line_words
);
    localparam int LANE_W = WORD_W / LANES;

    logic [BURST-1:0][WORD_W-1:0] mem [LINES];

    // Byte-masked commit of the pending line
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int w = 0; w < BURST; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (pend_be[w][l])
                        mem[pend_line][w][l*LANE_W +: LANE_W] <= pend_data[w][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Array line with the uncommitted write merged over it
    always_comb begin
        line_words = mem[rd_line];
        for (int w = 0; w < BURST; w++) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_valid && (pend_line == rd_line) && pend_be[w][l])
                    line_words[w][l*LANE_W +: LANE_W] = pend_data[w][l*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port import qdr_pkg::*; #(
    parameter int WORD_W = 18,
    parameter int LANES  = 2,
    parameter int AW     = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_edge,
    input  logic                           wr_sel_n,
    input  logic [AW-1:0]                  addr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [LANES-1:0]               wbyte_n,
    output logic                           wr_push,
    output logic                           pend_valid,
    output logic                           pend_commit,
    output logic [AW-3:0]                  pend_line,
    output logic [BURST-1:0][WORD_W-1:0]   pend_data,
    output logic [BURST-1:0][LANES-1:0]    pend_be
);
    wr_state_e   st, st_nx;
    pend_state_e pst, pst_nx;
    logic        again;
    logic [AW-1:0] wadr;
    logic        beat_on;
    logic [1:0]  bidx;
    logic [1:0]  phys;
    logic [BURST-1:0][WORD_W-1:0] asm_d, asm_d_nx;
    logic [BURST-1:0][LANES-1:0]  asm_be, asm_be_nx;

    always_comb begin
        unique case (st)
            WR_IDLE:  st_nx = (cmd_edge && !wr_sel_n) ? WR_ADDR : WR_IDLE;
            WR_ADDR:  st_nx = WR_BEAT0;
            WR_BEAT0: st_nx = WR_BEAT1;
            WR_BEAT1: st_nx = WR_BEAT2;
            WR_BEAT2: st_nx = WR_BEAT3;
            WR_BEAT3: st_nx = again ? WR_BEAT0 : WR_IDLE;
            default:  st_nx = WR_IDLE;
        endcase
    end

    always_comb begin
        unique case (pst)
            PD_EMPTY:  pst_nx = wr_push ? PD_HOLD : PD_EMPTY;
            PD_HOLD:   pst_nx = PD_COMMIT;
            PD_COMMIT: pst_nx = wr_push ? PD_HOLD : PD_EMPTY;
            default:   pst_nx = PD_EMPTY;
        endcase
    end

    always_comb begin
        beat_on = 1'b1;
        bidx    = 2'd0;
        unique case (st)
            WR_BEAT0: bidx = 2'd0;
            WR_BEAT1: bidx = 2'd1;
            WR_BEAT2: bidx = 2'd2;
            WR_BEAT3: bidx = 2'd3;
            default:  beat_on = 1'b0;
        endcase
        phys      = wadr[1:0] + bidx;
        asm_d_nx  = asm_d;
        asm_be_nx = asm_be;
        if (beat_on) begin
            asm_d_nx[phys]  = wdata;
            asm_be_nx[phys] = ~wbyte_n;
        end
    end

    assign wr_push     = (st == WR_BEAT3);
    assign pend_valid  = (pst != PD_EMPTY);
    assign pend_commit = (pst == PD_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= WR_IDLE;
            pst   <= PD_EMPTY;
            again <= 1'b0;
        end else begin
            st    <= st_nx;
            pst   <= pst_nx;
            again <= (st == WR_BEAT2) && cmd_edge && !wr_sel_n;
        end
    end

    always_ff @(posedge clk) begin
        if (st == WR_ADDR || (st == WR_BEAT3 && again))
            wadr <= addr;
        asm_d  <= asm_d_nx;
        asm_be <= asm_be_nx;
        if (wr_push) begin
            pend_data <= asm_d_nx;
            pend_be   <= asm_be_nx;
            pend_line <= wadr[AW-1:2];
        end
    end
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port import qdr_pkg::*; #(
    parameter int WORD_W = 18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_edge,
    input  logic                          rd_sel_n,
    input  logic                          lat_long,
    input  logic [1:0]                    start_off,
    input  logic [BURST-1:0][WORD_W-1:0]  line_words,
    output logic                          rd_acc,
    output logic                          rvalid,
    output logic [WORD_W-1:0]             rdata
);
    localparam int DEPTH = LAT_LONG + BURST - 1;
    localparam int IW    = $clog2(DEPTH);

    rd_state_e st, st_nx;
    logic [DEPTH-1:0]             sv, sv_nx;
    logic [DEPTH-1:0][WORD_W-1:0] sd, sd_nx;
    logic [IW-1:0]                base;

    assign rd_acc = (st == RD_IDLE) && cmd_edge && !rd_sel_n;

    always_comb begin
        unique case (st)
            RD_IDLE:  st_nx = rd_acc ? RD_HOLD1 : RD_IDLE;
            RD_HOLD1: st_nx = RD_HOLD2;
            RD_HOLD2: st_nx = RD_HOLD3;
            RD_HOLD3: st_nx = RD_IDLE;
            default:  st_nx = RD_IDLE;
        endcase
    end

    // Beat delay line: slot j reaches the output j+1 edges later
    always_comb begin
        base  = lat_long ? IW'(LAT_LONG - 1) : IW'(LAT_SHORT - 1);
        sv_nx = {1'b0, sv[DEPTH-1:1]};
        sd_nx = {{WORD_W{1'b0}}, sd[DEPTH-1:1]};
        if (rd_acc) begin
            for (int k = 0; k < BURST; k++) begin
                sv_nx[base + IW'(k)] = 1'b1;
                sd_nx[base + IW'(k)] = line_words[start_off + 2'(k)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv     <= '0;
            sd     <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            sv     <= sv_nx;
            sd     <= sd_nx;
            rvalid <= sv[0];
            rdata  <= sv[0] ? sd[0] : '0;
        end
    end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram import qdr_pkg::*; #(
    parameter int LINES  = 16,
    parameter int WORD_W = 18,
    parameter int LANE_W = 9,
    localparam int LANES = WORD_W / LANE_W,
    localparam int LAW   = $clog2(LINES),
    localparam int AW    = LAW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_long,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  wbyte_n,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic ph;
    logic cmd_edge;
    logic rd_acc;
    logic wr_push;
    logic wr_commit;
    logic pend_valid;
    logic [LAW-1:0]               pend_line;
    logic [BURST-1:0][WORD_W-1:0] pend_data;
    logic [BURST-1:0][LANES-1:0]  pend_be;
    logic [BURST-1:0][WORD_W-1:0] line_words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end
    assign cmd_edge = ~ph;

    qdr_wr_port #(.WORD_W(WORD_W), .LANES(LANES), .AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .cmd_edge(cmd_edge), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .wbyte_n(wbyte_n),
        .wr_push(wr_push), .pend_valid(pend_valid), .pend_commit(wr_commit),
        .pend_line(pend_line), .pend_data(pend_data), .pend_be(pend_be)
    );

    qdr_array #(.LINES(LINES), .WORD_W(WORD_W), .LANES(LANES)) u_arr (
        .clk(clk), .commit(wr_commit), .pend_valid(pend_valid),
        .pend_line(pend_line), .pend_data(pend_data), .pend_be(pend_be),
        .rd_line(addr[AW-1:2]), .line_words(line_words)
    );

    qdr_rd_port #(.WORD_W(WORD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .cmd_edge(cmd_edge), .rd_sel_n(rd_sel_n),
        .lat_long(lat_long), .start_off(addr[1:0]), .line_words(line_words),
        .rd_acc(rd_acc), .rvalid(rvalid), .rdata(rdata)
    );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lat_long,
    input logic              rd_acc,
    input logic              wr_push,
    input logic              wr_commit,
    input logic              rvalid,
    input logic [WORD_W-1:0] rdata
);
    // R6: idle output is zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);

    // R6: a valid run lasts at least one full burst
    a_r6_valid_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> ##1 rvalid ##1 rvalid ##1 rvalid);

    // R5: long latency
    a_r5_long_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && lat_long) |-> ##6 rvalid);

    // R5: short latency
    a_r5_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !lat_long) |-> ##3 rvalid);

    // R11: commit two beats after the last data beat
    a_r11_commit_delay: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push |-> ##2 wr_commit);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .rd_acc(rd_acc),
    .wr_push(wr_push), .wr_commit(wr_commit), .rvalid(rvalid), .rdata(rdata)
);

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 8;
    localparam int WORD_W = 18;
    localparam int LANE_W = 9;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int AW     = $clog2(LINES) + 2;

    typedef logic [3:0][WORD_W-1:0] burst_t;
    typedef logic [3:0][LANES-1:0]  ben_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lat_long = 1'b1;
    logic rd_sel_n = 1'b1;
    logic wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [LANES-1:0] wbyte_n = '1;
    logic [WORD_W-1:0] rdata;
    logic rvalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdr_burst_sram #(.LINES(LINES), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .wbyte_n(wbyte_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    int total = 0;
    int fails = 0;
    int n = 0;
    int last_rd = -100;
    int last_wr = -100;
    bit done = 0;
    string cur_tag = "R1";

    logic [WORD_W-1:0] ref_mem [LINES*4];
    logic [WORD_W-1:0] sd_data [64];
    logic [LANES-1:0]  sd_ben  [64];
    logic [AW-1:0]     sd_wa   [64];
    bit                ap_v    [64];
    logic [AW-1:0]     ap_a    [64];
    burst_t            ap_d    [64];
    ben_t              ap_b    [64];
    bit                ex_v    [64];
    logic [WORD_W-1:0] ex_d    [64];

    function automatic logic [WORD_W-1:0] rnd(int s);
        int x;
        x = s * 40503 + 4660;
        return WORD_W'(x ^ (x >>> 7));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (edge %0d)", req, act, exp, n);
        end
    endtask

    task automatic tick();
        int s;
        @(posedge clk);
        s = n % 64;
        if (ap_v[s]) begin
            for (int k = 0; k < 4; k++) begin
                int idx;
                idx = int'(ap_a[s][AW-1:2]) * 4 + ((int'(ap_a[s][1:0]) + k) % 4);
                for (int l = 0; l < LANES; l++)
                    if (ap_b[s][k][l]) ref_mem[idx][l*LANE_W +: LANE_W] = ap_d[s][k][l*LANE_W +: LANE_W];
            end
        end
        ap_v[s] = 0;
        sd_data[s] = rnd(n + 7777);
        sd_ben[s] = '0;
        n++;
        @(negedge clk);
        chk({"R6 ", cur_tag}, 32'(rvalid), 32'(ex_v[s]));
        chk(cur_tag, 32'(rdata), 32'(ex_d[s]));
        ex_v[s] = 0;
        ex_d[s] = '0;
    endtask

    // One command period: a command edge, then an address edge
    task automatic do_cycle(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                            burst_t wd, ben_t wbn, bit noise);
        int c;
        c = n;
        if (rd && (c - last_rd >= 4)) begin
            int lat;
            last_rd = c;
            lat = lat_long ? 5 : 2;
            for (int k = 0; k < 4; k++) begin
                ex_v[(c+lat+k)%64] = 1;
                ex_d[(c+lat+k)%64] = ref_mem[int'(ra[AW-1:2])*4 + (int'(ra[1:0]) + k) % 4];
            end
        end
        if (wr && (c - last_wr >= 4)) begin
            last_wr = c;
            sd_wa[(c+1)%64] = wa;
            for (int k = 0; k < 4; k++) begin
                sd_data[(c+2+k)%64] = wd[k];
                sd_ben[(c+2+k)%64]  = wbn[k];
            end
            ap_v[(c+5)%64] = 1;
            ap_a[(c+5)%64] = wa;
            ap_d[(c+5)%64] = wd;
            ap_b[(c+5)%64] = ~wbn;
        end
        rd_sel_n = !rd; wr_sel_n = !wr; addr = ra;
        wdata = sd_data[c%64]; wbyte_n = sd_ben[c%64];
        tick();
        rd_sel_n = !noise; wr_sel_n = !noise; addr = sd_wa[(c+1)%64];
        wdata = sd_data[(c+1)%64]; wbyte_n = sd_ben[(c+1)%64];
        sd_wa[(c+1)%64] = ~ra;
        tick();
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) do_cycle(0, '0, 0, '0, '0, '1, 0);
    endtask

    function automatic burst_t mkb(int seed);
        burst_t b;
        for (int k = 0; k < 4; k++) b[k] = rnd(seed * 4 + k);
        return b;
    endfunction

    function automatic ben_t mkben(int seed);
        ben_t b;
        for (int k = 0; k < 4; k++) b[k] = LANES'(seed * 3 + k);
        return b;
    endfunction

    // Write one line, then read it back d command periods later
    task automatic coh(int line, int d, int seed);
        logic [AW-1:0] a;
        a = AW'(line * 4 + seed % 4);
        for (int j = 0; j <= 6; j++)
            do_cycle(j == d, AW'(line * 4 + (seed + 1) % 4), j == 0, a, mkb(seed), mkben(seed), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            sd_data[i] = rnd(i + 31); sd_ben[i] = '0; sd_wa[i] = '0;
            ap_v[i] = 0; ex_v[i] = 0; ex_d[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'(rvalid), 32'd0);
        chk("R1", 32'(rdata), 32'd0);
        rst_n = 1'b1;

        // R3: fill every line with full-lane writes at rotating offsets
        cur_tag = "R3";
        for (int l = 0; l < LINES; l++)
            do_cycle(0, '0, 1, AW'(l * 4 + l % 4), mkb(l + 100), '0, 0);
        idle(4);

        // R2 R4 R5: read every line at every offset, long latency, noise on address beats
        cur_tag = "R2 R4 R5";
        for (int l = 0; l < LINES; l++)
            for (int o = 0; o < 4; o++) begin
                do_cycle(1, AW'(l * 4 + o), 0, '0, '0, '1, 1);
                do_cycle(0, '0, 0, '0, '0, '1, 1);
            end
        idle(4);

        // R8 R10: concurrent read and masked write to another line
        cur_tag = "R8 R10";
        for (int i = 0; i < LINES; i++) begin
            do_cycle(1, AW'(i * 4 + i % 4), 1, AW'(((i + 3) % LINES) * 4 + (i + 1) % 4),
                     mkb(i + 300), mkben(i), 0);
            do_cycle(0, '0, 0, '0, '0, '1, 0);
        end
        idle(4);
        cur_tag = "R3 R10";
        for (int l = 0; l < LINES; l++) begin
            do_cycle(1, AW'(l * 4), 0, '0, '0, '1, 0);
            do_cycle(0, '0, 0, '0, '0, '1, 0);
        end
        idle(4);

        // R9 R11: read after write at every distance
        cur_tag = "R9 R11";
        for (int d = 0; d <= 4; d++) coh(d % LINES, d, 400 + d);
        idle(4);

        // R7: selects held every command period, half are ignored
        cur_tag = "R7";
        for (int j = 0; j < 8; j++)
            do_cycle(1, AW'(j * 5 % (LINES * 4)), 1, AW'((j % LINES) * 4 + j % 4),
                     mkb(500 + j), mkben(j), 0);
        idle(4);
        for (int l = 0; l < LINES; l++) do_cycle(1, AW'(l * 4 + 2), 0, '0, '0, '1, 0);
        idle(6);

        // R5: short latency sweep and coherency
        lat_long = 1'b0;
        cur_tag = "R5 R4";
        for (int l = 0; l < LINES; l++)
            for (int o = 0; o < 4; o++) begin
                do_cycle(1, AW'(l * 4 + o), 0, '0, '0, '1, 1);
                do_cycle(0, '0, 0, '0, '0, '1, 0);
            end
        cur_tag = "R5 R9";
        for (int d = 0; d <= 4; d++) coh((d + 3) % LINES, d, 600 + d);
        idle(6);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule